// File: doc/BRIEF.md
# SPI Master with Status Handshake

This block is an 8-bit SPI master that a processor drives through a small register file of three addresses. Software sets a control byte (enable, master select, clock polarity, clock phase, interrupt enable and a three-bit rate code). It then writes a byte to the data address. The byte is shifted out on MOSI while the byte arriving on MISO is shifted in. When the eighth bit completes, the received byte is copied into a read buffer, a transfer-complete flag is raised and, if enabled, an interrupt request is driven.

The flags clear only through a handshake. Software reads the status address while a flag is up, then reads the data address. Until that handshake has finished, data writes are refused and recorded as a write collision. The slave-select input guards against another master on the bus. If it goes low while the block is an enabled master, the hardware drops the enable and master bits, aborts any transfer, returns SCK to idle and records a mode fault.

The transfer engine is a four-state machine. `ST_IDLE` moves to `ST_HALF_A` on an accepted write. `ST_HALF_A` moves to `ST_HALF_B` on a divider tick, which is the leading SCK edge. `ST_HALF_B` moves back to `ST_HALF_A` on a tick, which is the trailing edge, or moves to `ST_FINISH` after the trailing edge of the eighth bit. `ST_FINISH` returns to `ST_IDLE` after one cycle, and in that cycle the read buffer is loaded. A mode fault forces any state to `ST_IDLE`. All inputs are treated as synchronous to `clk`.

Top module: `spi_hs_master`

## Requirements
- R1: After reset, reads of address 0 (control), 1 (status) and 2 (data) all return 0, SCK is low and the interrupt request is low.
- R2: The rate code in control bits [2:0] selects an SCK period of 2^(code+1) system clocks. The transfer-complete flag becomes visible 16*2^code+1 clock edges after the edge that accepts the data write.
- R3: Control bit 4 (polarity) sets the SCK idle level. With control bit 3 (phase) at 0, the first bit is on MOSI before the first edge and MISO is sampled on leading edges. With phase 1, MOSI changes on leading edges and MISO is sampled on trailing edges. A full byte is exchanged correctly in all four combinations.
- R4: A byte written to address 2 while the block is enabled (control bit 6) and master (control bit 5), with no flag or transfer pending, appears on MOSI most significant bit first.
- R5: A read of address 2 returns the byte received during the last completed transfer.
- R6: Completion sets status bit 7. The interrupt request is high exactly while status bit 7 and control bit 7 (interrupt enable) are both set.
- R7: Status bit 7 clears only when a read of address 1 made while a flag was set is followed by a read of address 2. A read of address 2 without that preceding status read leaves the flag set.
- R8: A data write while status bit 7 is set, or while a transfer is running, starts nothing and sets status bit 6 (write collision).
- R9: Slave-select low while enabled and master clears control bits 6 and 5, sets status bit 4 (mode fault), aborts the transfer with SCK back at idle, and produces no completion.
- R10: The write-collision and mode-fault flags clear through the same status-read-then-data-read handshake as the completion flag.
- R11: A data write while the block is not an enabled master is ignored: no SCK activity and no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access; read side effects occur at the clock edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the addressed register, combinational |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ssel_i | input | 1 | Slave-select sense; must stay high while operating as master |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong state in the transfer engine shows up first on SCK. An extra or missing half period shifts the flag's arrival away from 16*2^code+1 edges, and a stuck phase corrupts the byte that the serial slave model captures within the same transfer. A flag-register fault is visible at the next status read: a flag that clears without the handshake, a collided write that starts clocks, or a mode fault that leaves the enable bit set. The bench therefore reads status straight after each stimulus and watches SCK for idle during the windows where nothing may move.

// File: rtl/spi_hs_pkg.sv
package spi_hs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HALF_A = 2'd1,
        ST_HALF_B = 2'd2,
        ST_FINISH = 2'd3
    } xfer_state_t;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    // Control byte, most significant field first
    typedef struct packed {
        logic       irq_en;
        logic       enable;
        logic       master;
        logic       cpol;
        logic       cpha;
        logic [2:0] rate;
    } ctrl_t;

    localparam int STAT_DONE_BIT = 7;
    localparam int STAT_WCOL_BIT = 6;
    localparam int STAT_MODF_BIT = 4;

endpackage

// File: rtl/spi_hs_clkdiv.sv
module spi_hs_clkdiv #(
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    // Half an SCK period lasts 2^rate system clocks
    localparam int CNT_W = (1 << RATE_W) - 1;
    localparam logic [CNT_W:0] ONE = {{CNT_W{1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   span;

    assign span = (ONE << rate) - ONE;
    assign tick = run && (cnt_q == span[CNT_W-1:0]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
        end
    end
endmodule

// File: rtl/spi_hs_shifter.sv
module spi_hs_shifter
    import spi_hs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] load_data,
    input  logic              abort,
    input  logic              tick,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              miso_i,
    output logic              sck_o,
    output logic              mosi_o,
    output logic              run,
    output logic              busy,
    output logic              done_pulse,
    output logic [DATA_W-1:0] rx_data,
    output xfer_state_t       state_o
);
    localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    xfer_state_t       state_q, state_d;
    logic [DATA_W-1:0] tx_q, rx_q;
    logic [CNT_W-1:0]  bit_q;
    logic              mosi_q;
    logic              lead_edge, trail_edge, last_bit;

    assign lead_edge  = (state_q == ST_HALF_A) && tick;
    assign trail_edge = (state_q == ST_HALF_B) && tick;
    assign last_bit   = (bit_q == LAST_BIT);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_HALF_A;
            ST_HALF_A: if (tick) state_d = ST_HALF_B;
            ST_HALF_B: if (tick) state_d = last_bit ? ST_FINISH : ST_HALF_A;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Datapath and serial outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q   <= '0;
            rx_q   <= '0;
            bit_q  <= '0;
            mosi_q <= 1'b0;
        end else if (start && state_q == ST_IDLE && !abort) begin
            bit_q <= '0;
            if (cpha) begin
                tx_q <= load_data;
            end else begin
                mosi_q <= load_data[DATA_W-1];
                tx_q   <= load_data << 1;
            end
        end else begin
            if (lead_edge) begin
                if (cpha) begin
                    mosi_q <= tx_q[DATA_W-1];
                    tx_q   <= tx_q << 1;
                end else begin
                    rx_q <= {rx_q[DATA_W-2:0], miso_i};
                end
            end
            if (trail_edge) begin
                bit_q <= bit_q + CNT_W'(1);
                if (cpha) begin
                    rx_q <= {rx_q[DATA_W-2:0], miso_i};
                end else begin
                    mosi_q <= tx_q[DATA_W-1];
                    tx_q   <= tx_q << 1;
                end
            end
        end
    end

    assign sck_o      = cpol ^ (state_q == ST_HALF_B);
    assign mosi_o     = mosi_q;
    assign run        = (state_q == ST_HALF_A) || (state_q == ST_HALF_B);
    assign busy       = (state_q != ST_IDLE);
    assign done_pulse = (state_q == ST_FINISH);
    assign rx_data    = rx_q;
    assign state_o    = state_q;
endmodule

// File: rtl/spi_hs_regs.sv
module spi_hs_regs
    import spi_hs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ssel_i,
    input  logic              busy,
    input  logic              done_pulse,
    input  logic [DATA_W-1:0] rx_data,
    output ctrl_t             ctrl,
    output logic              start,
    output logic [DATA_W-1:0] load_data,
    output logic              abort,
    output logic              irq_o,
    output logic              done_flag,
    output logic              wcol_flag,
    output logic              modf_flag
);
    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] rx_buf_q;
    logic              done_q, wcol_q, modf_q, armed_q;
    logic              wr_ctrl, wr_data, rd_stat, rd_data;
    logic              fault, collide, clear_seq, any_flag;
    logic [7:0]        stat_byte;

    assign wr_ctrl   = bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_data   = bus_wr && (bus_addr == ADDR_DATA);
    assign rd_stat   = bus_rd && (bus_addr == ADDR_STAT);
    assign rd_data   = bus_rd && (bus_addr == ADDR_DATA);

    assign fault     = ctrl_q.enable && ctrl_q.master && !ssel_i;
    assign any_flag  = done_q || wcol_q || modf_q;
    assign collide   = wr_data && (done_q || busy);
    assign clear_seq = rd_data && armed_q;
    assign start     = wr_data && !collide && ctrl_q.enable && ctrl_q.master && !fault;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[7:0]);
            if (fault) begin
                ctrl_q.enable <= 1'b0;
                ctrl_q.master <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q   <= 1'b0;
            wcol_q   <= 1'b0;
            modf_q   <= 1'b0;
            armed_q  <= 1'b0;
            rx_buf_q <= '0;
        end else begin
            if (clear_seq) begin
                done_q  <= 1'b0;
                wcol_q  <= 1'b0;
                modf_q  <= 1'b0;
                armed_q <= 1'b0;
            end else if (rd_stat && any_flag) begin
                armed_q <= 1'b1;
            end
            if (done_pulse) begin
                done_q   <= 1'b1;
                rx_buf_q <= rx_data;
            end
            if (collide) wcol_q <= 1'b1;
            if (fault)   modf_q <= 1'b1;
        end
    end

    always_comb begin
        stat_byte = 8'h00;
        stat_byte[STAT_DONE_BIT] = done_q;
        stat_byte[STAT_WCOL_BIT] = wcol_q;
        stat_byte[STAT_MODF_BIT] = modf_q;
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_CTRL: bus_rdata = DATA_W'(ctrl_q);
            ADDR_STAT: bus_rdata = DATA_W'(stat_byte);
            ADDR_DATA: bus_rdata = rx_buf_q;
            default:   bus_rdata = '0;
        endcase
    end

    assign ctrl      = ctrl_q;
    assign load_data = bus_wdata;
    assign abort     = fault;
    assign irq_o     = ctrl_q.irq_en && done_q;
    assign done_flag = done_q;
    assign wcol_flag = wcol_q;
    assign modf_flag = modf_q;
endmodule

// File: rtl/spi_hs_master.sv
module spi_hs_master
    import spi_hs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sck_o,
    output logic              mosi_o,
    input  logic              miso_i,
    input  logic              ssel_i,
    output logic              irq_o
);
    localparam int RATE_W = 3;

    ctrl_t             ctrl;
    xfer_state_t       xfer_state;
    logic              start, abort, tick, run, busy, done_pulse;
    logic              done_flag, wcol_flag, modf_flag;
    logic [DATA_W-1:0] load_data, rx_data;

    spi_hs_regs #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .ssel_i     (ssel_i),
        .busy       (busy),
        .done_pulse (done_pulse),
        .rx_data    (rx_data),
        .ctrl       (ctrl),
        .start      (start),
        .load_data  (load_data),
        .abort      (abort),
        .irq_o      (irq_o),
        .done_flag  (done_flag),
        .wcol_flag  (wcol_flag),
        .modf_flag  (modf_flag)
    );

    spi_hs_clkdiv #(.RATE_W(RATE_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .rate  (ctrl.rate),
        .tick  (tick)
    );

    spi_hs_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .load_data  (load_data),
        .abort      (abort),
        .tick       (tick),
        .cpol       (ctrl.cpol),
        .cpha       (ctrl.cpha),
        .miso_i     (miso_i),
        .sck_o      (sck_o),
        .mosi_o     (mosi_o),
        .run        (run),
        .busy       (busy),
        .done_pulse (done_pulse),
        .rx_data    (rx_data),
        .state_o    (xfer_state)
    );
endmodule

// File: rtl/spi_hs_checker.sv
module spi_hs_checker
    import spi_hs_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  bus_addr,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic        ssel_i,
    input logic        sck_o,
    input logic        irq_o,
    input ctrl_t       ctrl_reg,
    input xfer_state_t xfer_state,
    input logic        done_pulse,
    input logic        done_flag,
    input logic        wcol_flag,
    input logic        modf_flag
);
    assert_idle_sck_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_state == ST_IDLE) |-> (sck_o == ctrl_reg.cpol));

    assert_flag_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> done_flag);

    assert_irq_needs_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> done_flag);

    assert_flag_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && !(bus_rd && bus_addr == ADDR_DATA)) |=> done_flag);

    assert_collide_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_DATA && done_flag) |=> (wcol_flag && xfer_state == ST_IDLE));

    assert_fault_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_reg.enable && ctrl_reg.master && !ssel_i)
        |=> (modf_flag && !ctrl_reg.enable && !ctrl_reg.master && xfer_state == ST_IDLE));
endmodule

bind spi_hs_master spi_hs_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .ssel_i     (ssel_i),
    .sck_o      (sck_o),
    .irq_o      (irq_o),
    .ctrl_reg   (ctrl),
    .xfer_state (xfer_state),
    .done_pulse (done_pulse),
    .done_flag  (done_flag),
    .wcol_flag  (wcol_flag),
    .modf_flag  (modf_flag)
);

// File: tb/sim_spi_hs_master.sv
`timescale 1ns/1ps
module sim_spi_hs_master;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       sck_o, mosi_o, irq_o;
    logic       miso_r = 1'b0;
    logic       ssel_r = 1'b1;

    int checks = 0;
    int errors = 0;

    // scoreboard and slave-model state
    logic [7:0] exp_q[$];
    logic       tb_cpol = 1'b0;
    logic       tb_cpha = 1'b0;
    logic       mon_on = 1'b0;
    logic [7:0] s_sr = 8'h00;

    always #5 clk = ~clk;

    spi_hs_master u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sck_o     (sck_o),
        .mosi_o    (mosi_o),
        .miso_i    (miso_r),
        .ssel_i    (ssel_r),
        .irq_o     (irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle_window(input string tag, input logic lvl, input int n);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (sck_o !== lvl) bad++;
        end
        chk(tag, bad, 0);
    endtask

    // Driver: configure, push expected MOSI byte, start, time the completion
    task automatic do_xfer(input logic [2:0] rate, input logic cpol, input logic cpha,
                           input logic [7:0] txb, input logic [7:0] slvb, input logic clr);
        logic [7:0] d;
        int n = 0;
        bus_write(2'd0, {1'b1, 1'b1, 1'b1, cpol, cpha, rate});
        tb_cpol = cpol; tb_cpha = cpha;
        @(negedge clk);
        chk("R3 sck idle level", sck_o, cpol);
        s_sr = slvb;
        miso_r = cpha ? 1'b0 : slvb[7];
        exp_q.push_back(txb);
        mon_on = 1'b1;
        bus_write(2'd2, txb);
        while (!irq_o && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk("R2 completion edge count", n, 16 * (1 << rate) + 1);
        chk("R4 mosi byte consumed", exp_q.size(), 0);
        mon_on = 1'b0;
        if (clr) begin
            bus_read(2'd1, d);
            chk("R6 status done", d, 8'h80);
            bus_read(2'd2, d);
            chk("R5 received byte", d, slvb);
            bus_read(2'd1, d);
            chk("R7 status cleared", d, 8'h00);
            chk("R6 irq dropped", irq_o, 1'b0);
        end
    endtask

    // Monitor: serial slave model, pops expected bytes from the scoreboard
    initial begin
        logic prev = 1'b0;
        logic [7:0] got = 8'h00;
        int mcnt = 0;
        forever begin
            @(negedge clk);
            if (!mon_on) begin
                mcnt = 0;
            end else if (sck_o !== prev) begin
                if (sck_o !== tb_cpol) begin
                    // leading edge
                    if (!tb_cpha) begin
                        got = {got[6:0], mosi_o}; mcnt++;
                    end else begin
                        miso_r = s_sr[7]; s_sr = s_sr << 1;
                    end
                end else begin
                    // trailing edge
                    if (!tb_cpha) begin
                        s_sr = s_sr << 1; miso_r = s_sr[7];
                    end else begin
                        got = {got[6:0], mosi_o}; mcnt++;
                    end
                end
                if (mcnt == 8) begin
                    mcnt = 0;
                    if (exp_q.size() == 0) begin
                        chk("R4 unexpected mosi byte", got, 8'hxx);
                    end else begin
                        chk("R4 mosi msb first", got, exp_q.pop_front());
                    end
                end
            end
            prev = sck_o;
        end
    end

    // Watchdog
    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 sck low", sck_o, 1'b0);
        chk("R1 irq low", irq_o, 1'b0);
        bus_read(2'd0, d); chk("R1 control zero", d, 8'h00);
        bus_read(2'd1, d); chk("R1 status zero", d, 8'h00);
        bus_read(2'd2, d); chk("R1 data zero", d, 8'h00);

        // R2 R3 R4 R5 R6 R7: all four modes, several rates
        do_xfer(3'd0, 1'b0, 1'b0, 8'hA5, 8'h3C, 1'b1);
        do_xfer(3'd2, 1'b0, 1'b1, 8'h81, 8'h7E, 1'b1);
        do_xfer(3'd1, 1'b1, 1'b0, 8'h5A, 8'hC3, 1'b1);
        do_xfer(3'd0, 1'b1, 1'b1, 8'h0F, 8'hE1, 1'b1);
        do_xfer(3'd3, 1'b0, 1'b0, 8'hD2, 8'h96, 1'b1);

        // R7 data read without status read leaves the flag; R8 collision; R10 wcol clear
        do_xfer(3'd0, 1'b0, 1'b0, 8'h33, 8'h4B, 1'b0);
        bus_read(2'd2, d); chk("R5 buffered byte", d, 8'h4B);
        bus_read(2'd1, d); chk("R7 flag kept without handshake", d, 8'h80);
        bus_write(2'd2, 8'h11);
        bus_read(2'd1, d); chk("R8 write collision flagged", d, 8'hC0);
        idle_window("R8 no transfer after collision", 1'b0, 40);
        chk("R6 irq while flag set", irq_o, 1'b1);
        bus_read(2'd2, d); chk("R8 buffer unchanged", d, 8'h4B);
        bus_read(2'd1, d); chk("R10 collision and done cleared", d, 8'h00);

        // R11 data write while not an enabled master
        bus_write(2'd0, 8'h80);
        bus_write(2'd2, 8'h77);
        idle_window("R11 no sck activity", 1'b0, 200);
        bus_read(2'd1, d); chk("R11 no flag", d, 8'h00);

        // R9 mode fault mid-transfer, R10 modf clear
        bus_write(2'd0, 8'hE3);
        bus_write(2'd2, 8'hF0);
        repeat (40) @(negedge clk);
        ssel_r = 1'b0;
        @(negedge clk);
        chk("R9 sck back to idle", sck_o, 1'b0);
        repeat (3) @(negedge clk);
        ssel_r = 1'b1;
        bus_read(2'd0, d); chk("R9 enable and master dropped", d, 8'h83);
        idle_window("R9 transfer aborted", 1'b0, 300);
        chk("R9 no interrupt", irq_o, 1'b0);
        bus_read(2'd1, d); chk("R9 mode fault only", d, 8'h10);
        bus_read(2'd2, d);
        bus_read(2'd1, d); chk("R10 mode fault cleared", d, 8'h00);

        // recovery after a fault
        do_xfer(3'd1, 1'b1, 1'b1, 8'hC6, 8'h29, 1'b1);

        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule